// File: doc/BRIEF.md
# CPU hotplug status register bank

This block keeps a byte-addressed map of which processors are present, exposes that map to guest firmware through a read-only byte port, and raises a level-sensitive system control interrupt (SCI) whenever a hotplug event is latched and enabled. Each processor owns one bit of the map. Hotplug requests arrive on a one-cycle request strobe that carries a processor number and a plug or unplug flag. Every accepted request updates the processor's bit and latches the CPU hotplug event in the general-purpose event (GPE) status register.

The GPE status register also latches a PCI hotplug event from a neighbouring source. Firmware clears status bits by writing ones to them, and it controls which events can raise the interrupt through a directly written enable register. At reset the map is loaded from a vector that lists the processors present at power-up. A request for a processor number beyond the map is dropped and sets a sticky error flag.

Top module: `cpu_presence_bank`

## Requirements
- R1: When `rst` is high at a clock edge, the map is loaded from `init_present` (bit k is processor k). The same edge clears `gpe_sts`, `gpe_en`, `sci`, `id_err` and `io_rdata` to zero.
- R2: A read (`io_rd`) at address 0xAF00+N, with N from 0 to 31, returns map byte N on `io_rdata` after the next clock edge. Processor k occupies bit (k mod 8) of byte (k div 8). `io_rdata` holds its value in cycles without a read.
- R3: A valid plug request (`hp_plug`=1) sets the bit of processor `hp_id`, and an unplug request (`hp_plug`=0) clears it. All other bits keep their values.
- R4: Every request with `hp_id` below 256 sets `gpe_sts` bit 2 (0x04) at the next clock edge.
- R5: A pulse on `pci_hp_evt` sets `gpe_sts` bit 1 (0x02) at the next clock edge.
- R6: Writing `gpe_sts_wr` with a mask clears the `gpe_sts` bits that are 1 in the mask. If an event sets a bit in the same cycle, the set wins.
- R7: `gpe_en_wr` loads `gpe_en` with `gpe_en_wdata` at the next clock edge.
- R8: `sci` is a registered level. It is high in the cycle after one in which (`gpe_sts` AND `gpe_en`) has bit 1 or bit 2 set, and it is low otherwise. Other status bits never raise it.
- R9: Writes (`io_wr`) to any address change neither the map nor any output.
- R10: A request with `hp_id` of 256 or more leaves the map and `gpe_sts` untouched and sets `id_err`. `id_err` stays set until reset.
- R11: A read outside 0xAF00 to 0xAF1F returns 0xFF and changes no other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_present | input | 256 | Processors present at reset, bit k = processor k |
| hp_valid | input | 1 | Hotplug request strobe |
| hp_plug | input | 1 | 1 = plug, 0 = unplug |
| hp_id | input | 9 | Processor number of the request |
| pci_hp_evt | input | 1 | PCI hotplug event pulse |
| io_rd | input | 1 | Byte read strobe |
| io_wr | input | 1 | Byte write strobe (ignored) |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data (ignored) |
| io_rdata | output | 8 | Registered read data |
| gpe_sts_wr | input | 1 | Write-one-to-clear strobe for GPE status |
| gpe_sts_wdata | input | 8 | Mask of status bits to clear |
| gpe_en_wr | input | 1 | GPE enable write strobe |
| gpe_en_wdata | input | 8 | New GPE enable value |
| gpe_sts | output | 8 | GPE status register |
| gpe_en | output | 8 | GPE enable register |
| sci | output | 1 | Registered interrupt level |
| id_err | output | 1 | Sticky out-of-range request flag |

## Verification
The bench targets the following corner cases:
- A clear and an event set in the same cycle. A design that let the clear win would lose the hotplug event.
- Requests for processor 255 and for 256. A design with a truncated index would wrap 256 onto processor 0 instead of flagging an error.
- Addresses just below and just above the window. An off-by-one range check would return a map byte there instead of 0xFF.
- Enable bits outside the two hotplug classes. A design that masked the wrong bits would raise the interrupt from them.
- The one-cycle lag of the interrupt after status and enable change. A combinational or two-stage interrupt would be caught on the exact cycle where it differs.

// File: rtl/cpu_presence_pkg.sv
package cpu_presence_pkg;
  localparam int unsigned MAP_BYTES_DEF = 32;
  localparam int unsigned GPE_W_DEF     = 8;
  localparam int unsigned HP_CPU_BIT    = 2;
  localparam int unsigned HP_PCI_BIT    = 1;

  typedef enum logic {
    HP_UNPLUG = 1'b0,
    HP_PLUG   = 1'b1
  } hp_kind_e;
endpackage

// File: rtl/presence_map.sv
module presence_map #(
  parameter int unsigned MAP_BYTES = 32,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE      = 16'hAF00,
  localparam int unsigned IDX_W    = $clog2(MAP_BYTES),
  localparam int unsigned SEL_W    = IDX_W + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MAP_BYTES*8-1:0] init_present,
  input  logic                   upd_en,
  input  logic                   upd_plug,
  input  logic [SEL_W-1:0]       upd_sel,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data
);
  localparam logic [ADDR_W:0] WIN_LO = {1'b0, BASE[ADDR_W-1:0]};
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(MAP_BYTES);

  logic [7:0]        mem [MAP_BYTES];
  logic [IDX_W-1:0]  byte_sel;
  logic [2:0]        bit_sel;
  logic              in_win;
  logic [ADDR_W-1:0] off;

  assign byte_sel = upd_sel[SEL_W-1:3];
  assign bit_sel  = upd_sel[2:0];
  assign in_win   = ({1'b0, rd_addr} >= WIN_LO) && ({1'b0, rd_addr} < WIN_HI);
  assign off      = rd_addr - BASE[ADDR_W-1:0];

  for (genvar g = 0; g < MAP_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= init_present[g*8 +: 8];
      end else if (upd_en && (byte_sel == IDX_W'(g))) begin
        mem[g][bit_sel] <= upd_plug;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else if (rd_en) begin
      rd_data <= in_win ? mem[off[IDX_W-1:0]] : 8'hFF;
    end
  end

  // R3: the addressed bit takes the request's value
  p_bit_update_r3: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> mem[$past(byte_sel)][$past(bit_sel)] == $past(upd_plug));
  // R11: reads outside the window return all ones
  p_oob_read_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_win) |=> rd_data == 8'hFF);
  // R2: data holds when no read is issued
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/gpe_event_regs.sv
module gpe_event_regs #(
  parameter int unsigned GPE_W   = 8,
  parameter int unsigned CPU_BIT = 2,
  parameter int unsigned PCI_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_set,
  input  logic             pci_set,
  input  logic             clr_wr,
  input  logic [GPE_W-1:0] clr_mask,
  input  logic             en_wr,
  input  logic [GPE_W-1:0] en_data,
  output logic [GPE_W-1:0] sts,
  output logic [GPE_W-1:0] en,
  output logic             sci
);
  localparam logic [GPE_W-1:0] CPU_M    = GPE_W'(1) << CPU_BIT;
  localparam logic [GPE_W-1:0] PCI_M    = GPE_W'(1) << PCI_BIT;
  localparam logic [GPE_W-1:0] SCI_MASK = CPU_M | PCI_M;

  logic [GPE_W-1:0] set_vec;
  logic [GPE_W-1:0] clr_vec;

  assign set_vec = (cpu_set ? CPU_M : '0) | (pci_set ? PCI_M : '0);
  assign clr_vec = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      en  <= '0;
      sci <= 1'b0;
    end else begin
      sts <= (sts & ~clr_vec) | set_vec;
      if (en_wr) en <= en_data;
      sci <= |(sts & en & SCI_MASK);
    end
  end

  // R4: a CPU event is visible in status after the edge
  p_cpu_evt_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_set |=> sts[CPU_BIT]);
  // R6: cleared bits go low when no event competes
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !cpu_set && !pci_set) |=> (sts & $past(clr_mask)) == '0);
  // R8: interrupt rises only after an enabled hotplug bit was set
  p_sci_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sci) |-> ($past(sts & en) & SCI_MASK) != '0);
  // R8: interrupt falls only once no enabled hotplug bit remained
  p_sci_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sci) |-> ($past(sts & en) & SCI_MASK) == '0);
endmodule

// File: rtl/cpu_presence_bank.sv
module cpu_presence_bank #(
  parameter int unsigned MAP_BYTES = cpu_presence_pkg::MAP_BYTES_DEF,
  parameter int unsigned ID_W      = 9,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE      = 16'hAF00,
  parameter int unsigned GPE_W     = cpu_presence_pkg::GPE_W_DEF,
  localparam int unsigned NUM_IDS  = MAP_BYTES * 8,
  localparam int unsigned SEL_W    = $clog2(MAP_BYTES) + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDS-1:0] init_present,
  input  logic               hp_valid,
  input  logic               hp_plug,
  input  logic [ID_W-1:0]    hp_id,
  input  logic               pci_hp_evt,
  input  logic               io_rd,
  input  logic               io_wr,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  input  logic               gpe_sts_wr,
  input  logic [GPE_W-1:0]   gpe_sts_wdata,
  input  logic               gpe_en_wr,
  input  logic [GPE_W-1:0]   gpe_en_wdata,
  output logic [GPE_W-1:0]   gpe_sts,
  output logic [GPE_W-1:0]   gpe_en,
  output logic               sci,
  output logic               id_err
);
  import cpu_presence_pkg::*;

  localparam logic [ID_W:0] ID_LIMIT = (ID_W+1)'(NUM_IDS);

  logic     in_range;
  logic     accept;
  hp_kind_e kind;

  assign in_range = {1'b0, hp_id} < ID_LIMIT;
  assign accept   = hp_valid && in_range;
  assign kind     = hp_kind_e'(hp_plug);

  always_ff @(posedge clk) begin
    if (rst)                       id_err <= 1'b0;
    else if (hp_valid && !in_range) id_err <= 1'b1;
  end

  presence_map #(
    .MAP_BYTES (MAP_BYTES),
    .ADDR_W    (ADDR_W),
    .BASE      (BASE)
  ) u_map (
    .clk          (clk),
    .rst          (rst),
    .init_present (init_present),
    .upd_en       (accept),
    .upd_plug     (kind == HP_PLUG),
    .upd_sel      (hp_id[SEL_W-1:0]),
    .rd_en        (io_rd),
    .rd_addr      (io_addr),
    .rd_data      (io_rdata)
  );

  gpe_event_regs #(
    .GPE_W   (GPE_W),
    .CPU_BIT (HP_CPU_BIT),
    .PCI_BIT (HP_PCI_BIT)
  ) u_gpe (
    .clk      (clk),
    .rst      (rst),
    .cpu_set  (accept),
    .pci_set  (pci_hp_evt),
    .clr_wr   (gpe_sts_wr),
    .clr_mask (gpe_sts_wdata),
    .en_wr    (gpe_en_wr),
    .en_data  (gpe_en_wdata),
    .sts      (gpe_sts),
    .en       (gpe_en),
    .sci      (sci)
  );

  // R10: the error flag never drops outside reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    id_err |=> id_err);
  // R10: a dropped request leaves status alone
  p_oob_id_r10: assert property (@(posedge clk) disable iff (rst)
    (hp_valid && !in_range && !pci_hp_evt && !gpe_sts_wr) |=> $stable(gpe_sts));
  // R9: a write alone does not disturb read data
  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (io_wr && (io_wdata != 8'h00) && !io_rd) |=> $stable(io_rdata));
endmodule

// File: tb/cpu_presence_bank_tb.sv
module cpu_presence_bank_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] init_present;
  logic         hp_valid = 0, hp_plug = 0, pci_hp_evt = 0;
  logic [8:0]   hp_id = '0;
  logic         io_rd = 0, io_wr = 0;
  logic [15:0]  io_addr = '0;
  logic [7:0]   io_wdata = '0, io_rdata;
  logic         gpe_sts_wr = 0, gpe_en_wr = 0;
  logic [7:0]   gpe_sts_wdata = '0, gpe_en_wdata = '0, gpe_sts, gpe_en;
  logic         sci, id_err;

  int tests = 0, fails = 0, cycles = 0;

  // reference model state
  logic [255:0] m_map;
  logic [7:0]   m_sts, m_en, m_rdata;
  logic         m_sci, m_err;

  always #5 clk = ~clk;

  cpu_presence_bank u_dut (
    .clk(clk), .rst(rst), .init_present(init_present),
    .hp_valid(hp_valid), .hp_plug(hp_plug), .hp_id(hp_id),
    .pci_hp_evt(pci_hp_evt), .io_rd(io_rd), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .gpe_sts_wr(gpe_sts_wr), .gpe_sts_wdata(gpe_sts_wdata),
    .gpe_en_wr(gpe_en_wr), .gpe_en_wdata(gpe_en_wdata),
    .gpe_sts(gpe_sts), .gpe_en(gpe_en), .sci(sci), .id_err(id_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    logic nsci;
    int   off;
    if (rst) begin
      m_map = init_present; m_sts = 0; m_en = 0; m_sci = 0; m_err = 0; m_rdata = 0;
    end else begin
      nsci = ((m_sts & m_en & 8'h06) != 0);
      if (io_rd) begin
        off = int'(io_addr) - 'hAF00;
        m_rdata = (off >= 0 && off < 32) ? m_map[off*8 +: 8] : 8'hFF;
      end
      if (gpe_sts_wr) m_sts = m_sts & ~gpe_sts_wdata;
      if (pci_hp_evt) m_sts = m_sts | 8'h02;
      if (hp_valid) begin
        if (hp_id < 256) begin
          m_map[hp_id[7:0]] = hp_plug;
          m_sts = m_sts | 8'h04;
        end else m_err = 1;
      end
      if (gpe_en_wr) m_en = gpe_en_wdata;
      m_sci = nsci;
    end
  end

  // lockstep comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R2/R11 io_rdata", io_rdata, m_rdata);
      chk("R4/R5/R6 gpe_sts", gpe_sts, m_sts);
      chk("R7 gpe_en", gpe_en, m_en);
      chk("R8 sci", sci, m_sci);
      chk("R10 id_err", id_err, m_err);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk);
    hp_valid = 0; pci_hp_evt = 0; io_rd = 0; io_wr = 0;
    gpe_sts_wr = 0; gpe_en_wr = 0;
  endtask

  task automatic req(input logic plug, input int id);
    hp_valid = 1; hp_plug = plug; hp_id = 9'(id);
    idle();
  endtask

  task automatic rd(input int addr, input int exp, input string tag);
    io_rd = 1; io_addr = 16'(addr);
    idle();
    chk(tag, io_rdata, exp);
  endtask

  initial begin
    init_present = '0;
    init_present[0] = 1; init_present[1] = 1; init_present[2] = 1;
    init_present[255] = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    idle();
    // R1: reset state
    chk("R1 gpe_sts", gpe_sts, 0);
    chk("R1 gpe_en", gpe_en, 0);
    chk("R1 sci", sci, 0);
    chk("R1 id_err", id_err, 0);
    chk("R1 io_rdata", io_rdata, 0);
    rd('hAF00, 'h07, "R1 byte0 from init");
    rd('hAF1F, 'h80, "R2 last byte bit 7 = id 255");
    for (int i = 1; i < 31; i++) rd('hAF00 + i, 0, "R2 empty byte");
    // R11: just outside the window
    rd('hAEFF, 'hFF, "R11 below window");
    rd('hAF20, 'hFF, "R11 above window");
    chk("R11 no state change", gpe_sts, 0);
    // R3/R4: plug and unplug
    req(1, 5);
    chk("R4 status bit 2", gpe_sts, 'h04);
    rd('hAF00, 'h27, "R3 plug id 5");
    req(1, 200);
    rd('hAF19, 'h01, "R3 plug id 200");
    req(0, 1);
    rd('hAF00, 'h25, "R3 unplug id 1");
    req(1, 5);
    rd('hAF00, 'h25, "R3 replug no change");
    // R6: clear then R8 interrupt
    gpe_sts_wr = 1; gpe_sts_wdata = 'hFF; idle();
    chk("R6 cleared", gpe_sts, 0);
    gpe_en_wr = 1; gpe_en_wdata = 'h04; idle();
    chk("R8 no sci without status", sci, 0);
    req(1, 9);
    chk("R8 sci lags status", sci, 0);
    idle();
    chk("R8 sci asserted", sci, 1);
    gpe_sts_wr = 1; gpe_sts_wdata = 'h04; idle();
    chk("R8 sci holds one cycle", sci, 1);
    idle();
    chk("R8 sci dropped", sci, 0);
    // R5: PCI class with only its enable
    gpe_en_wr = 1; gpe_en_wdata = 'h02; idle();
    pci_hp_evt = 1; idle();
    chk("R5 pci status", gpe_sts, 'h02);
    idle();
    chk("R5 pci sci", sci, 1);
    // R8: non-hotplug enable bits never raise sci
    gpe_en_wr = 1; gpe_en_wdata = 'hF9; idle();
    req(1, 10);
    idle(); idle();
    chk("R8 masked classes", sci, 0);
    // R6: set wins over clear in the same cycle
    gpe_sts_wr = 1; gpe_sts_wdata = 'h06; hp_valid = 1; hp_plug = 0; hp_id = 9'd10;
    idle();
    chk("R6 set wins", gpe_sts, 'h04);
    // R10: out-of-range id
    gpe_sts_wr = 1; gpe_sts_wdata = 'hFF; idle();
    req(1, 256);
    chk("R10 error set", id_err, 1);
    chk("R10 status untouched", gpe_sts, 0);
    rd('hAF00, 'h25, "R10 id 256 no wrap to id 0");
    req(1, 511);
    idle();
    chk("R10 error sticky", id_err, 1);
    // R9: writes into the window are ignored
    io_wr = 1; io_addr = 16'hAF00; io_wdata = 'hFF; idle();
    io_wr = 1; io_addr = 16'hAF02; io_wdata = 'h55; idle();
    rd('hAF00, 'h25, "R9 write ignored");
    rd('hAF02, 'h00, "R9 write ignored byte2");
    // R7: enable write
    gpe_en_wr = 1; gpe_en_wdata = 'hA5; idle();
    chk("R7 enable loaded", gpe_en, 'hA5);
    // R1: reset again restores init
    rst = 1; idle(); rst = 0;
    rd('hAF00, 'h07, "R1 reload after reset");
    chk("R1 id_err cleared", id_err, 0);
    repeat (3) idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule